// File: doc/BRIEF.md
# Multi-channel DMA control and status register block

This block is the software-visible register file of a DMA controller with up to twelve channels. It sits on a simple 32-bit register bus with a write strobe and an address. Reads are combinational and return the addressed word in the same cycle. The block holds each channel's operating mode, transfer direction and interrupt enable, and drives them to the channel engines. It also keeps sticky per-channel interrupt and error flags, which the engines raise with single-cycle pulses.

Each engine also presents a live 2-bit activity state, and the status words report it. Every channel owns four 32-bit descriptor words in the address space, and these are driven to the engine. The channels are split into two banks. Channels 0 to 7 use control word 0 and status word 0. Channels 8 to 11 use control word 3 and status word 2, with bit positions counted from channel 8. A single interrupt line combines all flagged channels whose interrupt is enabled. The block does not fetch descriptors or move data.

Top module: `dma_csr_regs`

## Requirements
- R1: After reset, all modes, directions, interrupt enables, flags and descriptor words are zero, and `irq_out` is low.
- R2: Control word 0 (offset 0x00) holds a 4-bit field per channel n < 8 at bit 4n. Bits [1:0] are the mode (0 disabled, 1 scatter-gather, 2 one-shot) and bit 2 is the direction (1 = memory to device). Bit 3 reads 0, and a stored mode is never 3.
- R3: Control word 3 (offset 0x0C) holds the same 4-bit field for channels 8 to 11 at bit 4(n-8). Writing it leaves channels 0 to 7 unchanged.
- R4: Writing a mode value of 3 into a channel's field keeps that channel's stored mode. The direction bit in the same field is still written.
- R5: Control word 2 (offset 0x08) holds the interrupt enable of channel n at bit n for n < 8 and at bit n+8 for channels 8 to 11. All other bits read 0.
- R6: A one-cycle engine pulse sets the channel's interrupt or error flag, and the flag stays set. Status word 0 (offset 0x10) shows channel n < 8 with the interrupt flag at bit n, the error flag at bit n+8, and the live state (0 idle, 1 descriptor read, 2 waiting, 3 data access) at bits 16+2n.
- R7: Status word 2 (offset 0x18) uses the same layout for channels 8 to 11, indexed by n-8.
- R8: Writing a status word clears each flag whose bit is 1 in the written data and leaves the flags at 0-bits alone. When a set pulse and a clearing write hit the same flag in the same cycle, the flag stays set.
- R9: Channel n has four read/write descriptor words at 0x20+16n+{0,4,8,C}, which are driven on `ch_desc`. Addresses above the last channel read 0.
- R10: `irq_out` is high exactly when some channel has both its interrupt flag and its interrupt enable set.
- R11: Offsets 0x04, 0x14 and 0x1C read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| eng_irq_set | input | NCH | Per-channel interrupt event pulse |
| eng_err_set | input | NCH | Per-channel error event pulse |
| eng_state | input | 2*NCH | Per-channel activity state |
| ch_mode | output | 2*NCH | Per-channel mode |
| ch_dir | output | NCH | Per-channel direction |
| ch_irq_en | output | NCH | Per-channel interrupt enable |
| ch_desc | output | 128*NCH | Descriptor words, channel n at [128n +: 128], word w at +32w |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench targets the bank split. A design that put channels 8 to 11 at their absolute bit positions would return fields in the wrong place in control word 3, the upper half of control word 2 and status word 2. The bench also writes the mode value 3 to some channels while changing others in the same word. A design that stored it would corrupt the neighbours' modes. Further checks cover write-1-to-clear with 0-bits left alone, a set pulse landing in the same cycle as a clearing write (a wrong priority loses the event), the combined interrupt with flags on disabled channels only, the reserved offsets, and the address just past the last descriptor group.

// File: rtl/dma_csr_regs.sv
module dma_csr_regs #(
  parameter int NCH = 12,
  parameter int AW  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic [NCH-1:0]   eng_irq_set,
  input  logic [NCH-1:0]   eng_err_set,
  input  logic [2*NCH-1:0] eng_state,
  output logic [2*NCH-1:0] ch_mode,
  output logic [NCH-1:0]   ch_dir,
  output logic [NCH-1:0]   ch_irq_en,
  output logic [128*NCH-1:0] ch_desc,
  output logic             irq_out
);
  localparam int WA = AW - 2;
  localparam logic [WA-1:0] W_CTL0 = WA'(0);
  localparam logic [WA-1:0] W_CTL2 = WA'(2);
  localparam logic [WA-1:0] W_CTL3 = WA'(3);
  localparam logic [WA-1:0] W_STS0 = WA'(4);
  localparam logic [WA-1:0] W_STS2 = WA'(6);
  localparam logic [WA-1:0] W_DESC = WA'(8);

  logic [WA-1:0] wa;
  assign wa = addr[AW-1:2];

  logic [1:0]     mode_q [NCH];
  logic [NCH-1:0] dir_q, en_q, irqf_q, errf_q;
  logic [31:0]    desc_q [NCH][4];

  logic unused_bits;
  assign unused_bits = ^{addr[1:0], wdata};

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    localparam int  S  = n % 8;
    localparam bit  HI = (n >= 8);
    localparam int  EB = HI ? n + 8 : n;
    logic ctl_hit, sts_hit;
    logic [3:0] nib;
    assign ctl_hit = wr_en && (wa == (HI ? W_CTL3 : W_CTL0));
    assign sts_hit = wr_en && (wa == (HI ? W_STS2 : W_STS0));
    assign nib     = wdata[4*S +: 4];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mode_q[n] <= 2'd0;
        dir_q[n]  <= 1'b0;
        en_q[n]   <= 1'b0;
        irqf_q[n] <= 1'b0;
        errf_q[n] <= 1'b0;
      end else begin
        if (ctl_hit) begin
          if (nib[1:0] != 2'b11) mode_q[n] <= nib[1:0];
          dir_q[n] <= nib[2];
        end
        if (wr_en && wa == W_CTL2) en_q[n] <= wdata[EB];
        irqf_q[n] <= eng_irq_set[n] | (irqf_q[n] & ~(sts_hit & wdata[S]));
        errf_q[n] <= eng_err_set[n] | (errf_q[n] & ~(sts_hit & wdata[S+8]));
      end
    end

    for (genvar w = 0; w < 4; w++) begin : g_word
      localparam logic [WA-1:0] WADR = WA'(8 + 4*n + w);
      always_ff @(posedge clk) begin
        if (!rst_n) desc_q[n][w] <= '0;
        else if (wr_en && wa == WADR) desc_q[n][w] <= wdata;
      end
      assign ch_desc[128*n + 32*w +: 32] = desc_q[n][w];
    end

    assign ch_mode[2*n +: 2] = mode_q[n];
    assign ch_dir[n]         = dir_q[n];
    assign ch_irq_en[n]      = en_q[n];

    p_mode_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mode_q[n] != 2'b11);
    p_mode3_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_hit && nib[1:0] == 2'b11) |=> $stable(mode_q[n]));
    p_set_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_irq_set[n] || (irqf_q[n] && !sts_hit)) |=> irqf_q[n]);
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_hit && wdata[S] && !eng_irq_set[n]) |=> !irqf_q[n]);
  end

  assign irq_out = |(irqf_q & en_q);

  p_irq_needs_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irqf_q == '0) |-> !irq_out);

  logic [31:0] ctl0, ctl2, ctl3, sts0, sts2;
  always_comb begin
    ctl0 = '0; ctl2 = '0; ctl3 = '0; sts0 = '0; sts2 = '0;
    for (int n = 0; n < NCH; n++) begin
      if (n < 8) begin
        ctl0[4*(n%8) +: 4]     = {1'b0, dir_q[n], mode_q[n]};
        ctl2[n%8]              = en_q[n];
        sts0[n%8]              = irqf_q[n];
        sts0[(n%8)+8]          = errf_q[n];
        sts0[16+2*(n%8) +: 2]  = eng_state[2*n +: 2];
      end else begin
        ctl3[4*(n%8) +: 4]     = {1'b0, dir_q[n], mode_q[n]};
        ctl2[(n%8)+16]         = en_q[n];
        sts2[n%8]              = irqf_q[n];
        sts2[(n%8)+8]          = errf_q[n];
        sts2[16+2*(n%8) +: 2]  = eng_state[2*n +: 2];
      end
    end
  end

  logic [WA-1:0] doff;
  assign doff = wa - W_DESC;

  always_comb begin
    rdata = '0;
    case (wa)
      W_CTL0: rdata = ctl0;
      W_CTL2: rdata = ctl2;
      W_CTL3: rdata = ctl3;
      W_STS0: rdata = sts0;
      W_STS2: rdata = sts2;
      default: begin
        if (wa >= W_DESC && int'(doff[WA-1:2]) < NCH)
          rdata = desc_q[doff[WA-1:2]][doff[1:0]];
      end
    endcase
  end
endmodule

// File: tb/tb_dma_csr_regs.sv
module tb_dma_csr_regs;
  localparam int NCH = 12;
  localparam int AW  = 8;

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] eng_irq_set = '0, eng_err_set = '0;
  logic [2*NCH-1:0] eng_state = '0;
  logic [2*NCH-1:0] ch_mode;
  logic [NCH-1:0] ch_dir, ch_irq_en;
  logic [128*NCH-1:0] ch_desc;
  logic irq_out;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_csr_regs #(.NCH(NCH), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .eng_irq_set(eng_irq_set), .eng_err_set(eng_err_set),
    .eng_state(eng_state), .ch_mode(ch_mode), .ch_dir(ch_dir),
    .ch_irq_en(ch_irq_en), .ch_desc(ch_desc), .irq_out(irq_out));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); addr = a; #1;
    check(req, rdata, exp);
  endtask

  task automatic t_reset();
    rd_chk("R1", 8'h00, 0); rd_chk("R1", 8'h08, 0); rd_chk("R1", 8'h0C, 0);
    rd_chk("R1", 8'h10, 0); rd_chk("R1", 8'h20, 0);
    check("R1", {31'd0, irq_out}, 0);
  endtask

  task automatic t_ctl0();
    wr(8'h00, 32'h0000_0F61);
    rd_chk("R2", 8'h00, 32'h0000_0461);
    check("R2", {26'd0, ch_mode[5:0]}, 32'h0000_0009);
    check("R2", {29'd0, ch_dir[2:0]}, 32'h0000_0006);
    wr(8'h00, 32'h3333_3332);
    rd_chk("R4", 8'h00, 32'h0000_0022);
  endtask

  task automatic t_ctl3();
    wr(8'h0C, 32'h0000_B625);
    rd_chk("R3", 8'h0C, 32'h0000_0625);
    check("R3", {30'd0, ch_mode[17:16]}, 1);
    check("R3", {31'd0, ch_dir[8]}, 1);
    rd_chk("R3", 8'h00, 32'h0000_0022);
  endtask

  task automatic t_enable();
    wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R5", 8'h08, 32'h000F_00FF);
    check("R5", {20'd0, ch_irq_en}, 32'h0000_0FFF);
    wr(8'h08, 32'h0001_0001);
    rd_chk("R5", 8'h08, 32'h0001_0001);
  endtask

  task automatic t_status();
    eng_state = '0;
    eng_state[1:0] = 2'd3; eng_state[7:6] = 2'd2;
    eng_state[17:16] = 2'd1; eng_state[23:22] = 2'd2;
    @(negedge clk); eng_irq_set[1] = 1; eng_err_set[1] = 1; eng_irq_set[9] = 1;
    @(negedge clk); eng_irq_set = '0; eng_err_set = '0;
    repeat (2) @(negedge clk);
    rd_chk("R6", 8'h10, 32'h0083_0202);
    rd_chk("R7", 8'h18, 32'h0081_0002);
    check("R10", {31'd0, irq_out}, 0);
    wr(8'h08, 32'h0002_0000);
    #1 check("R10", {31'd0, irq_out}, 1);
  endtask

  task automatic t_clear();
    wr(8'h10, 32'h0000_0000);
    rd_chk("R8", 8'h10, 32'h0083_0202);
    wr(8'h10, 32'h0000_0002);
    rd_chk("R8", 8'h10, 32'h0083_0200);
    wr(8'h10, 32'h0000_0200);
    rd_chk("R8", 8'h10, 32'h0083_0000);
    wr(8'h18, 32'h0000_0002);
    rd_chk("R8", 8'h18, 32'h0081_0000);
    check("R10", {31'd0, irq_out}, 0);
    @(negedge clk); wr_en = 1; addr = 8'h10; wdata = 32'h4; eng_irq_set[2] = 1;
    @(negedge clk); wr_en = 0; eng_irq_set = '0;
    rd_chk("R8", 8'h10, 32'h0083_0004);
    wr(8'h10, 32'h4);
    rd_chk("R8", 8'h10, 32'h0083_0000);
  endtask

  task automatic t_desc();
    for (int w = 0; w < 4; w++) wr(8'(8'h20 + 4*w), 32'hA000_0000 + w);
    wr(8'hDC, 32'hCAFE_F00D);
    for (int w = 0; w < 4; w++) rd_chk("R9", 8'(8'h20 + 4*w), 32'hA000_0000 + w);
    rd_chk("R9", 8'hDC, 32'hCAFE_F00D);
    check("R9", ch_desc[11*128+96 +: 32], 32'hCAFE_F00D);
    check("R9", ch_desc[64 +: 32], 32'hA000_0002);
    wr(8'hE0, 32'h1234_5678);
    rd_chk("R9", 8'hE0, 0);
  endtask

  task automatic t_reserved();
    wr(8'h04, 32'hFFFF_FFFF); wr(8'h14, 32'hFFFF_FFFF); wr(8'h1C, 32'hFFFF_FFFF);
    rd_chk("R11", 8'h04, 0); rd_chk("R11", 8'h14, 0); rd_chk("R11", 8'h1C, 0);
    rd_chk("R11", 8'h00, 32'h0000_0022);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset(); t_ctl0(); t_ctl3(); t_enable(); t_status(); t_clear();
    t_desc(); t_reserved();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule